// File: doc/BRIEF.md
# ADC Result Window Limit Detector

This block sits beside a multi-channel successive approximation converter and screens every conversion result it is given. Each result arrives on a one-cycle strobe with its channel number. It is compared against two programmable unsigned limits under one of four conditions: inside the inclusive window, above the upper limit, below the lower limit, or outside the window. When the selected condition holds, a sticky flag for that channel is set and an interrupt request pulse is issued.

Software controls the block through a small register bus with per-byte write enables. The bus reaches a control word that holds the enable and the condition select, the two limits, and two status words that together hold one flag per channel. The interrupt handler reads the status words to find out which channels matched. It then clears those flags by writing ones to them. Clearing the enable bit freezes the status flags against new matches.

Top module: `adc_window_detect`

## Requirements
- R1: With condition code 2'b00, a result r matches when lower ≤ r ≤ upper, and both bounds are inclusive.
- R2: With condition code 2'b01, a result matches only when r > upper.
- R3: With condition code 2'b10, a result matches only when r < lower.
- R4: With condition code 2'b11, a result matches when r > upper or r < lower.
- R5: A match sets the flag of the strobed channel c. For c < 16 this is bit c of the status word at address 3. For c ≥ 16 it is bit c-16 of the status word at address 4. A strobe whose channel is N_CH or above changes no flag.
- R6: irq_o is high for exactly the one cycle after a clock edge at which at least one flag went from 0 to 1. A match on a flag that is already set gives no pulse.
- R7: While the enable bit is 0, no flag is set, whatever the strobes carry.
- R8: The control word at address 0 resets to 0. Bits 9:8 hold the condition code and bit 0 holds the enable. All other bits read 0 and ignore writes.
- R9: bus_be_i[1] gates writes to bits 15:8 and bus_be_i[0] gates writes to bits 7:0 of every register. A write with both enables set is a word write.
- R10: Flags are sticky. Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged. A match in the same cycle as a clear of the same flag keeps the flag set.
- R11: The upper limit sits at address 1 and the lower limit at address 2. Both are unsigned RES_W-bit values that reset to 0, and the bits above RES_W read 0. With lower > upper, condition 2'b00 never matches.
- R12: A result is evaluated only in a cycle where res_valid_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 3 | Register address |
| bus_be_i | input | 2 | Byte write enables (bit 1 = high byte) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| res_valid_i | input | 1 | Result strobe |
| res_ch_i | input | CH_W | Channel of the result |
| res_data_i | input | RES_W | Conversion result, unsigned |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The assertions assume that the converter side raises res_valid_i for single cycles, and that res_ch_i and res_data_i are defined whenever it does. They also assume that bus reads do not change state. The bench drives every strobe and bus access on the falling edge and holds each one for exactly one cycle. Its out-of-range channel is still a defined code within CH_W bits. It clears all flags before each sweep point, so every flag that rises can be traced to one known strobe.

// File: rtl/adc_wd_pkg.sv
package adc_wd_pkg;
  typedef enum logic [1:0] {
    WIN_IN    = 2'b00,
    WIN_ABOVE = 2'b01,
    WIN_BELOW = 2'b10,
    WIN_OUT   = 2'b11
  } win_mode_e;

  localparam logic [2:0] ADDR_CTRL    = 3'd0;
  localparam logic [2:0] ADDR_UPPER   = 3'd1;
  localparam logic [2:0] ADDR_LOWER   = 3'd2;
  localparam logic [2:0] ADDR_STAT_LO = 3'd3;
  localparam logic [2:0] ADDR_STAT_HI = 3'd4;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_MODE_LO = 8;

  function automatic logic [15:0] be_merge(input logic [15:0] old_v,
                                           input logic [15:0] new_v,
                                           input logic [1:0]  be);
    logic [15:0] m;
    m = {{8{be[1]}}, {8{be[0]}}};
    return (old_v & ~m) | (new_v & m);
  endfunction
endpackage

// File: rtl/adc_wd_cmp.sv
module adc_wd_cmp
  import adc_wd_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  win_mode_e        mode_i,
  input  logic [RES_W-1:0] res_i,
  input  logic [RES_W-1:0] lim_up_i,
  input  logic [RES_W-1:0] lim_lo_i,
  output logic             hit_o
);
  logic above, below;

  assign above = res_i > lim_up_i;
  assign below = res_i < lim_lo_i;

  always_comb begin
    unique case (mode_i)
      WIN_IN:    hit_o = !above && !below;
      WIN_ABOVE: hit_o = above;
      WIN_BELOW: hit_o = below;
      default:   hit_o = above || below;
    endcase
  end
endmodule

// File: rtl/adc_wd_regs.sv
module adc_wd_regs
  import adc_wd_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [2:0]       addr_i,
  input  logic [1:0]       be_i,
  input  logic [15:0]      wdata_i,
  output logic             en_o,
  output win_mode_e        mode_o,
  output logic [RES_W-1:0] lim_up_o,
  output logic [RES_W-1:0] lim_lo_o
);
  logic [15:0] ctrl_nxt, up_nxt, lo_nxt;

  assign ctrl_nxt = be_merge({6'b0, mode_o, 7'b0, en_o}, wdata_i, be_i);
  assign up_nxt   = be_merge(16'(lim_up_o), wdata_i, be_i);
  assign lo_nxt   = be_merge(16'(lim_lo_o), wdata_i, be_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      mode_o   <= WIN_IN;
      lim_up_o <= '0;
      lim_lo_o <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        ADDR_CTRL: begin
          en_o   <= ctrl_nxt[CTRL_EN_BIT];
          mode_o <= win_mode_e'(ctrl_nxt[CTRL_MODE_LO +: 2]);
        end
        ADDR_UPPER: lim_up_o <= up_nxt[RES_W-1:0];
        ADDR_LOWER: lim_lo_o <= lo_nxt[RES_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adc_wd_status.sv
module adc_wd_status
  import adc_wd_pkg::*;
#(
  parameter int N_CH = 20,
  parameter int CH_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [CH_W-1:0] set_ch_i,
  input  logic            clr_lo_i,
  input  logic            clr_hi_i,
  input  logic [1:0]      be_i,
  input  logic [15:0]     wdata_i,
  output logic [N_CH-1:0] stat_o,
  output logic            irq_o
);
  logic [15:0]     clr_m;
  logic [31:0]     clr32;
  logic [N_CH-1:0] rise;

  assign clr_m = wdata_i & {{8{be_i[1]}}, {8{be_i[0]}}};
  assign clr32 = {(clr_hi_i ? clr_m : 16'h0), (clr_lo_i ? clr_m : 16'h0)};

  for (genvar g = 0; g < N_CH; g++) begin : g_flag
    logic hit_g;
    assign hit_g   = set_i && (set_ch_i == CH_W'(g));
    assign rise[g] = hit_g && !stat_o[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         stat_o[g] <= 1'b0;
      else if (hit_g)      stat_o[g] <= 1'b1;  // set beats clear
      else if (clr32[g])   stat_o[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |rise;
  end
endmodule

// File: rtl/adc_window_detect.sv
module adc_window_detect
  import adc_wd_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int N_CH  = 20,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic [2:0]       bus_addr_i,
  input  logic [1:0]       bus_be_i,
  input  logic [15:0]      bus_wdata_i,
  output logic [15:0]      bus_rdata_o,
  input  logic             res_valid_i,
  input  logic [CH_W-1:0]  res_ch_i,
  input  logic [RES_W-1:0] res_data_i,
  output logic             irq_o
);
  logic             wr;
  logic             en_q;
  win_mode_e        mode_q;
  logic [RES_W-1:0] lim_up_q, lim_lo_q;
  logic             hit_w;
  logic [N_CH-1:0]  stat_q;
  logic [31:0]      stat32;

  assign wr     = bus_sel_i && bus_we_i;
  assign stat32 = 32'(stat_q);

  adc_wd_regs #(.RES_W(RES_W)) regs_i (
    .clk_i, .rst_ni,
    .wr_i     (wr),
    .addr_i   (bus_addr_i),
    .be_i     (bus_be_i),
    .wdata_i  (bus_wdata_i),
    .en_o     (en_q),
    .mode_o   (mode_q),
    .lim_up_o (lim_up_q),
    .lim_lo_o (lim_lo_q)
  );

  adc_wd_cmp #(.RES_W(RES_W)) cmp_i (
    .mode_i   (mode_q),
    .res_i    (res_data_i),
    .lim_up_i (lim_up_q),
    .lim_lo_i (lim_lo_q),
    .hit_o    (hit_w)
  );

  adc_wd_status #(.N_CH(N_CH), .CH_W(CH_W)) status_i (
    .clk_i, .rst_ni,
    .set_i    (res_valid_i && en_q && hit_w),
    .set_ch_i (res_ch_i),
    .clr_lo_i (wr && bus_addr_i == ADDR_STAT_LO),
    .clr_hi_i (wr && bus_addr_i == ADDR_STAT_HI),
    .be_i     (bus_be_i),
    .wdata_i  (bus_wdata_i),
    .stat_o   (stat_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      ADDR_CTRL:    bus_rdata_o = {6'b0, mode_q, 7'b0, en_q};
      ADDR_UPPER:   bus_rdata_o = 16'(lim_up_q);
      ADDR_LOWER:   bus_rdata_o = 16'(lim_lo_q);
      ADDR_STAT_LO: bus_rdata_o = stat32[15:0];
      ADDR_STAT_HI: bus_rdata_o = stat32[31:16];
      default:      bus_rdata_o = 16'h0;
    endcase
  end
endmodule

// File: rtl/adc_window_detect_chk.sv
module adc_window_detect_chk #(
  parameter int RES_W = 12,
  parameter int N_CH  = 20,
  parameter int CH_W  = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       bus_addr_i,
  input logic [15:0]      bus_rdata_o,
  input logic             res_valid_i,
  input logic [CH_W-1:0]  res_ch_i,
  input logic             irq_o,
  input logic             en_q,
  input logic [1:0]       mode_q,
  input logic [RES_W-1:0] lim_up_q,
  input logic [RES_W-1:0] lim_lo_q,
  input logic             hit_w,
  input logic [N_CH-1:0]  stat_q
);
  logic cur_bit;
  assign cur_bit = ((32'(stat_q) >> res_ch_i) & 32'd1) != 32'd0;

  AST_IRQ_NEEDS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((stat_q & ~$past(stat_q)) != '0));  // R6
  AST_RISE_GIVES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && en_q && hit_w && (32'(res_ch_i) < N_CH) && !cur_bit) |=> irq_o);  // R6
  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> ((stat_q & ~$past(stat_q)) == '0));  // R7
  AST_NO_SET_WITHOUT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> ((stat_q & ~$past(stat_q)) == '0));  // R12
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == 3'd0) |-> ((bus_rdata_o & 16'hFCFE) == 16'h0));  // R8
  AST_EMPTY_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b00 && lim_lo_q > lim_up_q) |-> !hit_w);  // R11
endmodule

bind adc_window_detect adc_window_detect_chk #(.RES_W(RES_W), .N_CH(N_CH), .CH_W(CH_W)) chk_i (
  .clk_i, .rst_ni, .bus_addr_i, .bus_rdata_o, .res_valid_i, .res_ch_i, .irq_o,
  .en_q, .mode_q(mode_q), .lim_up_q, .lim_lo_q, .hit_w, .stat_q
);

// File: tb/adc_window_detect_tb_top.sv
module adc_window_detect_tb_top;
  localparam int RES_W = 12;
  localparam int N_CH  = 20;
  localparam int CH_W  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [1:0] bus_be = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic res_valid = 0;
  logic [CH_W-1:0] res_ch = 0;
  logic [RES_W-1:0] res_data = 0;
  logic irq;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  adc_window_detect #(.RES_W(RES_W), .N_CH(N_CH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_sel_i(bus_sel), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_be_i(bus_be), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .res_valid_i(res_valid), .res_ch_i(res_ch), .res_data_i(res_data),
    .irq_o(irq)
  );

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    bus_addr = a; #1; v = int'(bus_rdata);
  endtask

  task automatic rd_stat(output int v);
    int lo, hi;
    rd(3'd3, lo); rd(3'd4, hi);
    v = (hi << 16) | lo;
  endtask

  task automatic clr_all();
    wr(3'd3, 2'b11, 16'hFFFF);
    wr(3'd4, 2'b11, 16'hFFFF);
  endtask

  // one strobe; afterwards we sit one negedge past the capturing edge
  task automatic strobe(int ch, int v, bit vld);
    @(negedge clk);
    res_valid = vld; res_ch = CH_W'(ch); res_data = RES_W'(v);
    @(negedge clk);
    res_valid = 0;
  endtask

  function automatic bit exp_hit(int mode, int v, int lo, int up);
    case (mode)
      0: return (v >= lo) && (v <= up);
      1: return v > up;
      2: return v < lo;
      default: return (v > up) || (v < lo);
    endcase
  endfunction

  task automatic point(int mode, bit en, int lo, int up, int ch, int v, string tag);
    int s, e;
    clr_all();
    strobe(ch, v, 1'b1);
    e = (en && exp_hit(mode, v, lo, up)) ? 1 : 0;
    chk({tag, " irq"}, int'(irq), e);
    rd_stat(s);
    chk({tag, " flag"}, s, e << ch);
  endtask

  task automatic cfg(int mode, bit en, int lo, int up);
    wr(3'd1, 2'b11, 16'(up));
    wr(3'd2, 2'b11, 16'(lo));
    wr(3'd0, 2'b11, 16'((mode << 8) | int'(en)));
  endtask

  initial begin
    int v, s;
    string tags[4] = '{"R1", "R2", "R3", "R4"};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(3'd0, v); chk("R8 ctrl reset", v, 0);
    rd(3'd1, v); chk("R11 upper reset", v, 0);
    rd(3'd2, v); chk("R11 lower reset", v, 0);
    rd_stat(v);  chk("R5 status reset", v, 0);
    chk("R6 irq reset", int'(irq), 0);

    // control word reserved bits and byte lanes
    wr(3'd0, 2'b11, 16'hFFFF); rd(3'd0, v); chk("R8 reserved bits", v, 16'h0301);
    wr(3'd0, 2'b11, 16'h0000);
    wr(3'd0, 2'b01, 16'hFFFF); rd(3'd0, v); chk("R9 low byte only", v, 16'h0001);
    wr(3'd0, 2'b10, 16'h0200); rd(3'd0, v); chk("R9 high byte only", v, 16'h0201);
    wr(3'd0, 2'b00, 16'h0000); rd(3'd0, v); chk("R9 no lanes", v, 16'h0201);
    wr(3'd1, 2'b10, 16'hAB00); rd(3'd1, v); chk("R11 upper high byte", v, 16'h0B00);
    wr(3'd1, 2'b01, 16'h00CD); rd(3'd1, v); chk("R9 upper low byte", v, 16'h0BCD);

    // sweeps over all conditions
    for (int m = 0; m < 4; m++) begin
      cfg(m, 1'b1, 100, 200);
      for (int x = 0; x < 4096; x += 53) point(m, 1'b1, 100, 200, x % N_CH, x, tags[m]);
      foreach (tags[k]) begin end
      for (int b = 0; b < 9; b++) begin
        int bv;
        bv = (b < 3) ? 99 + b : (b < 6) ? 199 + b - 3 : (b == 6) ? 0 : (b == 7) ? 4095 : 150;
        point(m, 1'b1, 100, 200, (b * 3) % N_CH, bv, tags[m]);
      end
    end

    // disabled: nothing sets (R7)
    cfg(3, 1'b0, 100, 200);
    for (int x = 0; x < 4096; x += 311) point(3, 1'b0, 100, 200, x % N_CH, x, "R7");

    // lower above upper (R11)
    cfg(0, 1'b1, 300, 200);
    for (int x = 0; x < 4096; x += 97) point(0, 1'b1, 300, 200, x % N_CH, x, "R11");
    cfg(3, 1'b1, 300, 200);
    point(3, 1'b1, 300, 200, 7, 250, "R4 inverted limits");

    // channel mapping and out-of-range (R5)
    cfg(0, 1'b1, 100, 200);
    clr_all(); strobe(19, 150, 1'b1);
    rd(3'd4, v); chk("R5 ch19 in hi word", v, 16'h0008);
    rd(3'd3, v); chk("R5 lo word untouched", v, 0);
    clr_all(); strobe(25, 150, 1'b1);
    chk("R5 out-of-range irq", int'(irq), 0);
    rd_stat(v); chk("R5 out-of-range flags", v, 0);

    // valid low (R12)
    clr_all(); strobe(4, 150, 1'b0);
    chk("R12 no valid irq", int'(irq), 0);
    rd_stat(v); chk("R12 no valid flag", v, 0);

    // pulse width and sticky behaviour (R6, R10)
    clr_all(); strobe(5, 150, 1'b1);
    chk("R6 pulse high", int'(irq), 1);
    @(negedge clk); chk("R6 pulse one cycle", int'(irq), 0);
    strobe(5, 300, 1'b1);
    rd_stat(v); chk("R10 sticky on miss", v, 1 << 5);
    strobe(5, 160, 1'b1);
    chk("R6 no pulse when already set", int'(irq), 0);
    wr(3'd3, 2'b11, 16'h0000);
    rd_stat(v); chk("R10 write 0 keeps", v, 1 << 5);
    // clear and match same cycle
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 3'd3; bus_be = 2'b11; bus_wdata = 16'h0020;
    res_valid = 1; res_ch = 5; res_data = 150;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; res_valid = 0;
    rd_stat(v); chk("R10 set wins over clear", v, 1 << 5);
    wr(3'd3, 2'b01, 16'h0020);
    rd_stat(v); chk("R10 clear by write 1", v, 0);
    // clear gated by byte lane
    strobe(12, 150, 1'b1);
    wr(3'd3, 2'b01, 16'h1000);
    rd_stat(s); chk("R9 clear masked by lane", s, 1 << 12);
    wr(3'd3, 2'b10, 16'h1000);
    rd_stat(s); chk("R9 clear via high lane", s, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule